// File: doc/BRIEF.md
# Long-Silence Mute Detector

This block decides when a two-channel audio path has been silent long enough that an external analog mute switch should engage. Once per sample period it looks at the left and right 16-bit samples, at which channels the current output routing actually uses, and at whether each channel's attenuation counter has run down to zero. It then raises a single mute-control bit after a long, unbroken run of silent sample periods.

Four situations count as silence, and any one of them is enough. Both samples are zero. Every channel that the routing selects carries a zero sample. The routing selects neither channel. Both attenuation counters are at zero. A counter advances on each sample strobe while one of these holds. The flag rises on the strobe that completes 2^HOLD_LOG2 consecutive silent periods. With the default HOLD_LOG2 of 14, this is about 0.37 s at 44.1 kHz. A single period that is not silent clears the count and drops the flag on that same strobe.

After reset the flag is forced high while an initialization phase of INIT_STROBES sample periods runs. It drops on the first data strobe that follows.

Top module: `silmute_detector`

## Requirements
- R1: While rst_n is low at a clock edge, mute_o is 1 from the following cycle, and it is still 1 in the first cycle after reset is released.
- R2: After reset, mute_o stays 1 through the first INIT_STROBES strobes (default 8), whatever the inputs. The next strobe is the first data strobe, and it drives mute_o to 0 even when that period is silent.
- R3: A period in which both smp_left and smp_right are zero is silent.
- R4: A period is silent when at least one of sel_left and sel_right is 1 and every selected channel's sample is zero. The sample of a channel whose select bit is 0 has no effect on this condition.
- R5: A period in which sel_left and sel_right are both 0 is silent, whatever the samples.
- R6: A period in which att_zero_left and att_zero_right are both 1 is silent. Only one of them being 1 does not make the period silent.
- R7: mute_o rises in the cycle after the data strobe that completes 2^HOLD_LOG2 consecutive silent data strobes, and not earlier. It stays 1 on further silent strobes.
- R8: A data strobe whose period is not silent clears the run and drives mute_o to 0 in the next cycle. A fresh full run is then needed before mute_o rises again.
- R9: A sample counts as zero only when all 16 bits are 0. A single set bit at either end, 0x0001 or 0x8000, makes it non-zero.
- R10: Cycles with smp_stb low neither advance the run nor change mute_o, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | One-cycle pulse, once per sample period |
| smp_left | input | 16 | Left sample, two's complement |
| smp_right | input | 16 | Right sample, two's complement |
| sel_left | input | 1 | Output routing uses the left input |
| sel_right | input | 1 | Output routing uses the right input |
| att_zero_left | input | 1 | Left attenuation counter is at zero |
| att_zero_right | input | 1 | Right attenuation counter is at zero |
| mute_o | output | 1 | Mute control, 1 = engage analog mute |

## Verification
Every result of this block is a single flop, mute_o, which is updated at the clock edge that samples a strobe. A response to a strobe is therefore due exactly one cycle later, and between strobes mute_o holds its value. The bench drives each strobe on a falling edge and reads mute_o at the next falling edge, half a cycle after the updating edge. For a run it counts strobes exactly: it checks that mute_o is still 0 after 2^HOLD_LOG2−1 silent strobes and 1 after one more. Idle cycles are inserted to show that nothing moves without a strobe.

// File: rtl/silmute_pkg.sv
// Shared definitions for the long-silence mute detector.
// Assumes a two-channel audio path, left at index 0 and right at index 1.
package silmute_pkg;
    localparam int unsigned CH_LEFT  = 0;
    localparam int unsigned CH_RIGHT = 1;
    localparam int unsigned NUM_CH   = 2;

    // One flag per kind of silence; any set flag qualifies the period.
    typedef struct packed {
        logic both_zero;   // both samples zero
        logic sel_zero;    // every routed channel is zero
        logic none_sel;    // routing selects no channel
        logic att_zero;    // both attenuation counters zero
    } cond_t;
endpackage

// File: rtl/silmute_zero_det.sv
// Flags one sample as zero when every bit is clear.
// Assumes: the sample is stable in the strobe cycle. Purely combinational.
module silmute_zero_det #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic                is_zero
);
    // Reduce all bits; a single set bit makes the sample non-zero.
    always_comb begin
        is_zero = ~|sample;
    end
endmodule

// File: rtl/silmute_qualify.sv
// Combines the four silence conditions into one qualify bit.
// Assumes: per-channel inputs are indexed with the package channel indices.
module silmute_qualify
    import silmute_pkg::*;
(
    input  logic [NUM_CH-1:0] ch_zero,
    input  logic [NUM_CH-1:0] ch_sel,
    input  logic [NUM_CH-1:0] ch_att_zero,
    output logic              qual
);
    cond_t cond;

    // Evaluate each condition separately, then OR them together.
    always_comb begin
        cond.both_zero = &ch_zero;
        cond.sel_zero  = (|ch_sel) && (&(ch_zero | ~ch_sel));
        cond.none_sel  = ~|ch_sel;
        cond.att_zero  = &ch_att_zero;
        qual           = |cond;
    end
endmodule

// File: rtl/silmute_init_seq.sv
// Counts the initialization strobes that follow reset.
// Assumes: INIT_STROBES is small. init_done stays high until the next reset.
module silmute_init_seq #(
    parameter int unsigned INIT_STROBES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic init_done
);
    localparam int unsigned CW = $clog2(INIT_STROBES + 2);
    localparam logic [CW-1:0] LAST = CW'(INIT_STROBES);

    logic [CW-1:0] cnt;

    // Advance once per strobe until the initialization phase is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (stb && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Initialization is over once the full count has been reached.
    always_comb begin
        init_done = (cnt == LAST);
    end
endmodule

// File: rtl/silmute_hold_ctr.sv
// Saturating counter of consecutive silent data strobes.
// Assumes: eval pulses only on data strobes. hit marks the strobe that
// completes 2^HOLD_LOG2 silent periods, and every later silent strobe.
module silmute_hold_ctr #(
    parameter int unsigned HOLD_LOG2 = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eval,
    input  logic qual,
    output logic hit
);
    localparam logic [HOLD_LOG2-1:0] FULL = {HOLD_LOG2{1'b1}};

    logic [HOLD_LOG2-1:0] cnt;

    // Count silent strobes and saturate; clear on any non-silent strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (eval) begin
            if (!qual) begin
                cnt <= '0;
            end else if (cnt != FULL) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // The current strobe completes the run when the count is already full.
    always_comb begin
        hit = qual && (cnt == FULL);
    end
endmodule

// File: rtl/silmute_detector.sv
// Top of the long-silence mute detector.
// Raises mute_o after 2^HOLD_LOG2 consecutive silent sample periods, and
// holds it high from reset through INIT_STROBES initialization strobes.
// Assumes: smp_stb is one cycle wide, and all inputs are valid in that cycle.
module silmute_detector
    import silmute_pkg::*;
#(
    parameter int unsigned SAMPLE_W     = 16,
    parameter int unsigned HOLD_LOG2    = 14,
    parameter int unsigned INIT_STROBES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_stb,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                sel_left,
    input  logic                sel_right,
    input  logic                att_zero_left,
    input  logic                att_zero_right,
    output logic                mute_o
);
    logic [SAMPLE_W-1:0] samples [NUM_CH];
    logic [NUM_CH-1:0]   ch_zero;
    logic [NUM_CH-1:0]   ch_sel;
    logic [NUM_CH-1:0]   ch_att_zero;
    logic                qual;
    logic                init_done;
    logic                eval;
    logic                hit;

    // Gather the per-channel inputs into arrays indexed by channel.
    always_comb begin
        samples[CH_LEFT]         = smp_left;
        samples[CH_RIGHT]        = smp_right;
        ch_sel[CH_LEFT]          = sel_left;
        ch_sel[CH_RIGHT]         = sel_right;
        ch_att_zero[CH_LEFT]     = att_zero_left;
        ch_att_zero[CH_RIGHT]    = att_zero_right;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_zero
        silmute_zero_det #(.SAMPLE_W(SAMPLE_W)) zero_i (
            .sample  (samples[ch]),
            .is_zero (ch_zero[ch])
        );
    end

    silmute_qualify qual_i (
        .ch_zero     (ch_zero),
        .ch_sel      (ch_sel),
        .ch_att_zero (ch_att_zero),
        .qual        (qual)
    );

    silmute_init_seq #(.INIT_STROBES(INIT_STROBES)) init_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (smp_stb),
        .init_done (init_done)
    );

    // Only strobes after initialization are data strobes.
    always_comb begin
        eval = smp_stb && init_done;
    end

    silmute_hold_ctr #(.HOLD_LOG2(HOLD_LOG2)) hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .eval  (eval),
        .qual  (qual),
        .hit   (hit)
    );

    // Mute flop: set by reset, then updated only on data strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute_o <= 1'b1;
        end else if (eval) begin
            mute_o <= hit;
        end
    end
endmodule

// File: rtl/silmute_checker.sv
// Assertions for silmute_detector, attached to it by bind.
// Keeps its own count of consecutive silent data strobes to check the window.
module silmute_checker #(
    parameter int unsigned HOLD_LOG2 = 14
) (
    input logic clk,
    input logic rst_n,
    input logic smp_stb,
    input logic init_done,
    input logic qual,
    input logic mute_o
);
    localparam logic [HOLD_LOG2:0] HOLD_V  = {1'b1, {HOLD_LOG2{1'b0}}};
    localparam logic [HOLD_LOG2:0] HOLD_M1 = {1'b0, {HOLD_LOG2{1'b1}}};

    logic [HOLD_LOG2:0] run;
    logic               past_ok;

    // Reference run length of silent data strobes, saturating at the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (smp_stb && init_done) begin
            if (!qual) begin
                run <= '0;
            end else if (run != HOLD_V) begin
                run <= run + 1'b1;
            end
        end
    end

    // Marks that the previous cycle was also out of reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    // R1: reset forces the mute flag high.
    a_r1_reset_mute: assert property (@(posedge clk)
        !rst_n |=> mute_o);

    // R2: mute stays high throughout initialization.
    a_r2_init_high: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |=> mute_o);

    // R7: no rise before the full window of silent strobes.
    a_r7_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(mute_o)) |-> (run == HOLD_V));

    // R7: a silent strobe completing the window raises or keeps the flag.
    a_r7_rise_due: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && init_done && qual && (run >= HOLD_M1)) |=> mute_o);

    // R8: a non-silent data strobe drops the flag.
    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && init_done && !qual) |=> !mute_o);

    // R10: without a strobe the flag holds.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(smp_stb)) |-> $stable(mute_o));
endmodule

bind silmute_detector silmute_checker #(.HOLD_LOG2(HOLD_LOG2)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .init_done (init_done),
    .qual      (qual),
    .mute_o    (mute_o)
);

// File: tb/silmute_detector_tb_top.sv
`timescale 1ns/1ps
// Directed bench for silmute_detector: one task per scenario.
module silmute_detector_tb_top;
    localparam int unsigned HL   = 10;
    localparam int unsigned HOLD = 1 << HL;
    localparam int unsigned INIT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic [15:0] smp_left = 16'h1111;
    logic [15:0] smp_right = 16'h2222;
    logic        sel_left = 1'b1;
    logic        sel_right = 1'b1;
    logic        att_zero_left = 1'b0;
    logic        att_zero_right = 1'b0;
    logic        mute_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    silmute_detector #(.SAMPLE_W(16), .HOLD_LOG2(HL), .INIT_STROBES(INIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
        .smp_left(smp_left), .smp_right(smp_right),
        .sel_left(sel_left), .sel_right(sel_right),
        .att_zero_left(att_zero_left), .att_zero_right(att_zero_right),
        .mute_o(mute_o)
    );

    task automatic check(input logic exp, input string tag);
        checks++;
        if (mute_o !== exp) begin
            errors++;
            $display("FAIL %s: mute_o=%0b expected %0b", tag, mute_o, exp);
        end
    endtask

    // n back-to-back strobes; returns at the falling edge after the last one.
    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) smp_stb = 1'b1;
        end
        @(negedge clk) smp_stb = 1'b0;
    endtask

    task automatic set_in(input logic [15:0] l, input logic [15:0] r,
                          input logic sl, input logic sr,
                          input logic al, input logic ar);
        smp_left = l; smp_right = r; sel_left = sl; sel_right = sr;
        att_zero_left = al; att_zero_right = ar;
    endtask

    // Non-silent strobe to clear the run before a scenario.
    task automatic clear_run();
        set_in(16'h1111, 16'h2222, 1, 1, 0, 0);
        strobes(1);
        check(1'b0, "R8 clear");
    endtask

    // R1, R2: reset state and initialization phase.
    task automatic t_reset_init(input bit silent_first);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(1'b1, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b1, "R1 after release");
        if (silent_first) set_in(16'h0000, 16'h0000, 1, 1, 1, 1);
        else              set_in(16'h0F0F, 16'h7000, 1, 1, 0, 0);
        strobes(INIT);
        check(1'b1, "R2 init strobes");
        strobes(1);
        check(1'b0, "R2 first data strobe");
    endtask

    // R3, R7, R8: both samples zero.
    task automatic t_both_zero();
        clear_run();
        set_in(16'h0000, 16'h0000, 1, 1, 0, 0);
        strobes(HOLD - 1);
        check(1'b0, "R7 one short");
        strobes(1);
        check(1'b1, "R3 R7 rise");
        strobes(5);
        check(1'b1, "R7 stays high");
        smp_left = 16'h0042;
        strobes(1);
        check(1'b0, "R8 drop");
    endtask

    // R4: routed-channel zero; unrouted data ignored.
    task automatic t_sel_zero();
        clear_run();
        set_in(16'h0000, 16'h1234, 1, 0, 0, 0);
        strobes(HOLD);
        check(1'b1, "R4 left routed zero");
        clear_run();
        set_in(16'h0000, 16'h1234, 0, 1, 0, 0);
        strobes(HOLD + 2);
        check(1'b0, "R4 routed right non-zero");
    endtask

    // R5: no channel routed.
    task automatic t_none_sel();
        clear_run();
        set_in(16'h5555, 16'hAAAA, 0, 0, 0, 0);
        strobes(HOLD);
        check(1'b1, "R5 none routed");
    endtask

    // R6: attenuation counters.
    task automatic t_att();
        clear_run();
        set_in(16'h5555, 16'hAAAA, 1, 1, 1, 1);
        strobes(HOLD);
        check(1'b1, "R6 both att zero");
        clear_run();
        set_in(16'h5555, 16'hAAAA, 1, 1, 1, 0);
        strobes(HOLD + 2);
        check(1'b0, "R6 one att zero");
    endtask

    // R9, R8: single-bit samples break the run and restart it.
    task automatic t_single_bit();
        clear_run();
        set_in(16'h0000, 16'h0000, 1, 1, 0, 0);
        strobes(HOLD - 1);
        smp_left = 16'h8000;
        strobes(1);
        check(1'b0, "R9 msb set");
        smp_left = 16'h0000;
        strobes(HOLD - 1);
        check(1'b0, "R8 restart needs full run");
        smp_right = 16'h0001;
        strobes(1);
        check(1'b0, "R9 lsb set");
        smp_right = 16'h0000;
        strobes(HOLD);
        check(1'b1, "R9 all zero rise");
    endtask

    // R10: idle cycles neither count nor change the flag.
    task automatic t_no_strobe();
        clear_run();
        set_in(16'h0000, 16'h0000, 1, 1, 0, 0);
        strobes(HOLD - 1);
        repeat (20) @(negedge clk);
        check(1'b0, "R10 idle does not count");
        strobes(1);
        check(1'b1, "R10 rise after idle");
        set_in(16'h7FFF, 16'h8001, 1, 1, 0, 0);
        repeat (20) @(negedge clk);
        check(1'b1, "R10 idle with data holds");
        strobes(1);
        check(1'b0, "R8 drop after idle");
    endtask

    initial begin
        t_reset_init(1'b0);
        t_both_zero();
        t_sel_zero();
        t_none_sel();
        t_att();
        t_single_bit();
        t_no_strobe();
        t_reset_init(1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule